// File: doc/BRIEF.md
# DMA 2D Destination Address Generator

This block holds and advances the 32-bit write pointer for one channel of a DMA engine. Software loads a start address and sets up the channel: whether the address moves with each burst, the beat width as a power of two, the number of beats per burst, a signed per-block offset and a signed per-repeat offset. The transfer engine then reports burst, block and block-repeat completions. The block moves the pointer by the matching amounts, so the output always names the location of the next write.

In linked-list operation, the end of a descriptor's data transfer can replace the pointer with an address taken from that descriptor. The replacement happens only when the descriptor asks for it. When the channel is enabled, the block checks that the pointer is aligned to the beat width, and it checks any reloaded address the same way. A misaligned pointer raises a sticky setting error, which blocks transfers and freezes the pointer. The error stays until software writes a fresh address and enables the channel again.

Top module: `dma_dst_addr_gen`

## Requirements
- R1: After reset, `dst_addr` is 0, `setting_err` is 0 and `issue_ok` is 1.
- R2: A cycle with `cfg_wr` high loads `cfg_addr` into `dst_addr` on the next edge. This takes precedence over every other update.
- R3: With `inc_mode` = 0, a burst completion leaves `dst_addr` unchanged.
- R4: With `inc_mode` = 1, a burst completion adds (`burst_len_m1` + 1) × 2^`dw_log2` bytes. `burst_len_m1` gives beats minus one (1 to 64 beats), and `dw_log2` gives a beat of 1, 2, 4 or 8 bytes.
- R5: A block completion adds the 13-bit unsigned `blk_off` when `blk_dec` = 0, and subtracts it when `blk_dec` = 1.
- R6: With `rpt_en` = 1, a repeat completion adds the 16-bit unsigned `rpt_off` when `rpt_dec` = 0, and subtracts it when `rpt_dec` = 1.
- R7: With `rpt_en` = 0, repeat completions have no effect, so the channel behaves as a 1D channel.
- R8: Completions arriving in the same cycle are summed and applied as one update on the next edge.
- R9: All address arithmetic wraps modulo 2^32.
- R10: A descriptor-done pulse (`ll_done`) with `ll_upd` = 1 loads `ll_addr`. With `ll_upd` = 0 the address is kept.
- R11: An address is misaligned when `addr[2:0]` AND (2^`dw_log2` − 1) is nonzero. An enable pulse (`ch_en`) on a misaligned address sets `setting_err` and drops `issue_ok`. A reload of a misaligned `ll_addr` does the same.
- R12: While `setting_err` is 1, completion events and descriptor reloads do not change `dst_addr`.
- R13: `setting_err` stays set across a new address write. It is cleared only by an enable pulse on an aligned address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Software write of start address |
| cfg_addr | input | 32 | Start address value |
| ch_en | input | 1 | Channel enable pulse; triggers alignment check |
| inc_mode | input | 1 | 1: advance per burst; 0: fixed |
| dw_log2 | input | 2 | log2 of beat width in bytes |
| burst_len_m1 | input | 6 | Beats per burst minus one |
| blk_off | input | 13 | Block offset magnitude |
| blk_dec | input | 1 | 1: subtract block offset |
| rpt_off | input | 16 | Repeat offset magnitude |
| rpt_dec | input | 1 | 1: subtract repeat offset |
| rpt_en | input | 1 | Enables the repeat offset (2D capability) |
| ev_burst | input | 1 | Destination burst completed |
| ev_block | input | 1 | Destination block completed |
| ev_repeat | input | 1 | Block repeat completed |
| ll_done | input | 1 | Descriptor data transfer finished |
| ll_upd | input | 1 | Descriptor requests an address update |
| ll_addr | input | 32 | Address carried by the descriptor |
| dst_addr | output | 32 | Address of the next write |
| setting_err | output | 1 | Sticky misalignment error |
| issue_ok | output | 1 | Transfers may be issued |

## Verification
The assertions assume that the configuration fields stay still during the cycle they are sampled in. They also treat `cfg_wr`, `ll_done` and the event pulses as single-cycle strobes, since each check compares the pointer against its value one edge earlier. The bench changes inputs only on falling edges, holds the configuration steady while it sends events, and sends every strobe for exactly one cycle. Its expected addresses come from a 64-bit arithmetic model that is then truncated to 32 bits.

// File: rtl/dma_dst_addr_gen.sv
module dma_dst_addr_gen #(
  parameter int AW  = 32,
  parameter int BLW = 6,
  parameter int BOW = 13,
  parameter int ROW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic [AW-1:0]  cfg_addr,
  input  logic           ch_en,
  input  logic           inc_mode,
  input  logic [1:0]     dw_log2,
  input  logic [BLW-1:0] burst_len_m1,
  input  logic [BOW-1:0] blk_off,
  input  logic           blk_dec,
  input  logic [ROW-1:0] rpt_off,
  input  logic           rpt_dec,
  input  logic           rpt_en,
  input  logic           ev_burst,
  input  logic           ev_block,
  input  logic           ev_repeat,
  input  logic           ll_done,
  input  logic           ll_upd,
  input  logic [AW-1:0]  ll_addr,
  output logic [AW-1:0]  dst_addr,
  output logic           setting_err,
  output logic           issue_ok
);

  logic [AW-1:0] addr;
  logic          err;
  logic [2:0]    mask;
  logic [AW-1:0] beats, burst_term, blk_mag, blk_term, rpt_mag, rpt_term, delta;
  logic          do_burst, do_rpt, reload, any_ev;

  assign mask       = 3'((4'd1 << dw_log2) - 4'd1);
  assign beats      = AW'(burst_len_m1) + AW'(1);
  assign do_burst   = ev_burst & inc_mode;
  assign do_rpt     = ev_repeat & rpt_en;
  assign burst_term = do_burst ? (beats << dw_log2) : '0;
  assign blk_mag    = AW'(blk_off);
  assign blk_term   = !ev_block ? '0 : (blk_dec ? -blk_mag : blk_mag);
  assign rpt_mag    = AW'(rpt_off);
  assign rpt_term   = !do_rpt ? '0 : (rpt_dec ? -rpt_mag : rpt_mag);
  assign delta      = burst_term + blk_term + rpt_term;
  assign any_ev     = do_burst | ev_block | do_rpt;
  assign reload     = ll_done & ll_upd & ~err;

  function automatic logic misal(input logic [AW-1:0] a, input logic [2:0] m);
    return (a[2:0] & m) != 3'd0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      err  <= 1'b0;
    end else begin
      if (cfg_wr)              addr <= cfg_addr;
      else if (reload)         addr <= ll_addr;
      else if (!err && any_ev) addr <= addr + delta;

      if (ch_en)                 err <= misal(cfg_wr ? cfg_addr : addr, mask);
      else if (reload && !cfg_wr) err <= misal(ll_addr, mask);
    end
  end

  assign dst_addr    = addr;
  assign setting_err = err;
  assign issue_ok    = ~err;

  // R2
  assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> dst_addr == $past(cfg_addr));

  // R3
  assert_fixed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_mode && ev_burst && !ev_block && !ev_repeat && !cfg_wr && !ll_done) |=> $stable(dst_addr));

  // R7
  assert_no_repeat_1d_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rpt_en && ev_repeat && !ev_burst && !ev_block && !cfg_wr && !ll_done) |=> $stable(dst_addr));

  // R12
  assert_err_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (setting_err && !cfg_wr) |=> $stable(dst_addr));

  // R11
  assert_err_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(setting_err) |-> ($past(ch_en) || $past(ll_done && ll_upd)));

  // R13
  assert_err_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (setting_err && !ch_en) |=> setting_err);

  // R10
  assert_ll_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_done && ll_upd && !setting_err && !cfg_wr) |=> dst_addr == $past(ll_addr));

endmodule

// File: tb/dma_dst_addr_gen_bench.sv
`timescale 1ns/1ps
module dma_dst_addr_gen_bench;
  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n = 0, cfg_wr = 0, ch_en = 0, inc_mode = 0, blk_dec = 0, rpt_dec = 0, rpt_en = 0;
  logic ev_burst = 0, ev_block = 0, ev_repeat = 0, ll_done = 0, ll_upd = 0;
  logic [31:0] cfg_addr = 0, ll_addr = 0;
  logic [1:0]  dw_log2 = 0;
  logic [5:0]  burst_len_m1 = 0;
  logic [12:0] blk_off = 0;
  logic [15:0] rpt_off = 0;
  logic [31:0] dst_addr;
  logic setting_err, issue_ok;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [31:0] exp_a;

  dma_dst_addr_gen u_dma_dst_addr_gen (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic load(input logic [31:0] a);
    cfg_wr = 1; cfg_addr = a; tick(); cfg_wr = 0; exp_a = a;
  endtask

  task automatic enable();
    ch_en = 1; tick(); ch_en = 0;
  endtask

  function automatic logic [31:0] model(input logic [31:0] a, input bit b, input bit bk, input bit rp);
    longint s = longint'(a);
    if (b && inc_mode) s += (longint'(burst_len_m1) + 1) * (longint'(1) << dw_log2);
    if (bk) s += blk_dec ? -longint'(blk_off) : longint'(blk_off);
    if (rp && rpt_en) s += rpt_dec ? -longint'(rpt_off) : longint'(rpt_off);
    return s[31:0];
  endfunction

  task automatic ev(input bit b, input bit bk, input bit rp);
    ev_burst = b; ev_block = bk; ev_repeat = rp;
    tick();
    ev_burst = 0; ev_block = 0; ev_repeat = 0;
    exp_a = model(exp_a, b, bk, rp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R1 addr", dst_addr, 0);
    chk("R1 err", {31'b0, setting_err}, 0);
    chk("R1 ok", {31'b0, issue_ok}, 1);

    load(32'h0000_1000); chk("R2 load", dst_addr, exp_a);
    cfg_wr = 1; cfg_addr = 32'h0000_2000; ll_done = 1; ll_upd = 1; ll_addr = 32'h0000_3000;
    ev_burst = 1; inc_mode = 1; tick();
    cfg_wr = 0; ll_done = 0; ll_upd = 0; ev_burst = 0;
    chk("R2 priority", dst_addr, 32'h0000_2000);

    inc_mode = 0; load(32'h0000_1000); enable();
    for (int i = 0; i < 3; i++) begin ev(1,0,0); chk("R3 fixed", dst_addr, exp_a); end

    inc_mode = 1;
    for (int d = 0; d < 4; d++) begin
      for (int k = 0; k < 6; k++) begin
        dw_log2 = 2'(d);
        burst_len_m1 = (k == 0) ? 6'd0 : (k == 1) ? 6'd1 : (k == 2) ? 6'd7 : (k == 3) ? 6'd30 : (k == 4) ? 6'd31 : 6'd63;
        load(32'h0001_0000); enable();
        ev(1,0,0); chk("R4 burst", dst_addr, exp_a);
        ev(1,0,0); chk("R4 burst2", dst_addr, exp_a);
      end
    end

    inc_mode = 0; dw_log2 = 0;
    for (int k = 0; k < 3; k++) begin
      blk_off = (k == 0) ? 13'd0 : (k == 1) ? 13'd1 : 13'h1FFF;
      load(32'h0010_0000); enable();
      blk_dec = 0; ev(0,1,0); chk("R5 block add", dst_addr, exp_a);
      blk_dec = 1; ev(0,1,0); ev(0,1,0); chk("R5 block sub", dst_addr, exp_a);
    end

    rpt_en = 1;
    for (int k = 0; k < 3; k++) begin
      rpt_off = (k == 0) ? 16'd0 : (k == 1) ? 16'd3 : 16'hFFFF;
      load(32'h0100_0000); enable();
      rpt_dec = 0; ev(0,0,1); chk("R6 repeat add", dst_addr, exp_a);
      rpt_dec = 1; ev(0,0,1); ev(0,0,1); chk("R6 repeat sub", dst_addr, exp_a);
    end

    rpt_en = 0; rpt_off = 16'h0100; rpt_dec = 0;
    load(32'h0100_0000); ev(0,0,1);
    chk("R7 ignored", dst_addr, 32'h0100_0000);

    rpt_en = 1; inc_mode = 1; dw_log2 = 2; burst_len_m1 = 3;
    blk_off = 13'h40; blk_dec = 1; rpt_off = 16'h200; rpt_dec = 0;
    load(32'h0200_0000); enable();
    ev(1,1,1); chk("R8 combined", dst_addr, 32'h0200_01D0);
    chk("R8 model", dst_addr, exp_a);

    dw_log2 = 3; burst_len_m1 = 1; blk_off = 0; rpt_off = 0;
    load(32'hFFFF_FFF8); enable();
    ev(1,0,0); chk("R9 wrap up", dst_addr, 32'h0000_0008);
    inc_mode = 0; blk_off = 13'h10; blk_dec = 1;
    ev(0,1,0); chk("R9 wrap down", dst_addr, 32'hFFFF_FFF8);

    dw_log2 = 2; load(32'h0000_4000); enable();
    ll_done = 1; ll_upd = 0; ll_addr = 32'h0000_8000; tick(); ll_done = 0;
    chk("R10 no update", dst_addr, 32'h0000_4000);
    ll_done = 1; ll_upd = 1; tick(); ll_done = 0; ll_upd = 0;
    chk("R10 update", dst_addr, 32'h0000_8000);

    dw_log2 = 2; load(32'h0000_1002); enable();
    chk("R11 err set", {31'b0, setting_err}, 1);
    chk("R11 no issue", {31'b0, issue_ok}, 0);
    inc_mode = 1; blk_off = 13'h20;
    ev(1,1,1); chk("R12 frozen", dst_addr, 32'h0000_1002);
    ll_done = 1; ll_upd = 1; ll_addr = 32'h0000_9000; tick(); ll_done = 0; ll_upd = 0;
    chk("R12 reload blocked", dst_addr, 32'h0000_1002);
    load(32'h0000_1004);
    chk("R13 sticky", {31'b0, setting_err}, 1);
    enable();
    chk("R13 cleared", {31'b0, setting_err}, 0);

    dw_log2 = 0; load(32'h0000_1003); enable();
    chk("R11 byte ok", {31'b0, setting_err}, 0);
    dw_log2 = 1; load(32'h0000_1001); enable();
    chk("R11 half bad", {31'b0, setting_err}, 1);

    dw_log2 = 3; load(32'h0000_1000); enable();
    ll_done = 1; ll_upd = 1; ll_addr = 32'h0000_2004; tick(); ll_done = 0; ll_upd = 0;
    chk("R11 reload addr", dst_addr, 32'h0000_2004);
    chk("R11 reload err", {31'b0, setting_err}, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule